// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 262,144 words by 4 bits. It takes one single-word read or write request at a time, over a request/acknowledge handshake, and plays it out on the RAM's address lines, its active-low chip enable, output enable and write enable, and a 4-bit data bus that is split here into an output, an output enable and an input. Every strobe phase is a whole number of clock cycles, derived at elaboration from the RAM's nanosecond minimums and the clock period, rounding up. With the default 8 ns clock this gives a one-cycle address setup, a one-cycle write pulse, a one-cycle write hold, a two-cycle read strobe, a one-cycle bus turnaround and a 12,500-cycle power-up wait.

The controller is a single state machine with eight states. ST_PWRUP holds off all access until the power-up timer expires (transition to ST_IDLE). ST_IDLE accepts a request: a read goes to ST_RSTROBE; a write goes to ST_WSETUP, or to ST_TURN first when the previous access was a read. The write path is ST_TURN → ST_WSETUP → ST_WPULSE → ST_WHOLD → ST_DONE, and the read path is ST_RSTROBE → ST_DONE. Each timed state leaves when its phase counter reaches its last cycle. ST_DONE raises chip enable, pulses the acknowledge and returns to ST_IDLE.

The host holds `host_req` and the command fields steady until it sees `host_ack`, then drops or replaces the request in the following cycle. All RAM-side outputs come from registers, so the strobes carry no decode glitches.

Top module: `sram_async_ctrl`

## Requirements
- R1: For the first 12,500 clock cycles after reset, chip enable stays high and no acknowledge is given. A request held during this wait is served once the wait ends.
- R2: A write, counted in cycles after the edge that accepts it, shows the strobe code {ce_n,oe_n,we_n,dq_oe} = 0110 for one cycle, then 0101 for one cycle with the write data on `mem_dq_out`, then 0110 for one cycle. In the fourth cycle `host_ack` is high, and the word can be read back afterwards.
- R3: A read shows the strobe code 0010 for two cycles. The data on `mem_dq_in` at the end of the second cycle is registered on `host_rdata`, and the acknowledge comes in the third cycle.
- R4: Output enable is high in every cycle in which write enable is low.
- R5: `mem_dq_oe` is high only while write enable is low and chip enable is low. It never overlaps a cycle in which the RAM drives the bus.
- R6: A write that directly follows a read gets one extra leading cycle with code 1110, so its acknowledge comes one cycle later. A read after a write, a read after a read and a write after a write get no extra cycle.
- R7: `host_ack` is high for exactly one cycle per completed request.
- R8: Chip enable is high outside access phases, including the acknowledge cycle. After reset, chip enable, output enable and write enable are high and both `mem_dq_oe` and `host_ack` are low.
- R9: `host_rdata` keeps the last read word until the next read completes. A write does not change it.
- R10: While chip enable is low, `mem_addr` equals the request's address and does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request pending; held until acknowledge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address of the request |
| host_wdata | input | 4 | Data to write |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 4 | Last word read |
| mem_addr | output | 18 | RAM address lines |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | 4 | Data toward the RAM bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 4 | Data from the RAM bus |

## Verification
The assertions watch the cycle-level safety rules on every clock. These are: output enable is high whenever write enable is low; the data bus is driven only inside the write pulse; the write pulse is at least its minimum length; the read strobe has write enable high; the acknowledge is one cycle wide with chip enable high; the address is frozen while chip enable is low; nothing is selected before the power-up timer expires. Only the bench scenarios can show the rest. That covers the exact phase sequence and acknowledge latency per access type, the extra turnaround cycle when a write follows a read, data surviving a round trip through a RAM model that returns corrupt data until its access time has passed, and the read register holding across writes.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_TURN,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RSTROBE,
        ST_DONE
    } ctrl_state_e;

    // Whole clock cycles covering a minimum time; at least one cycle.
    function automatic int ps_to_cyc(input int ps, input int clk_ps);
        if (ps <= 0) return 1;
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_pwrup_timer.sv
module sram_pwrup_timer #(
    parameter int CYCLES = 12500
) (
    input  logic clk,
    input  logic rst,
    output logic ready
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ready <= 1'b0;
        end else if (!ready) begin
            if (cnt_q == CW'(CYCLES - 1)) ready <= 1'b1;
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - CW'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ASU_C  = 1,
    parameter int WP_C   = 1,
    parameter int WH_C   = 1,
    parameter int RD_C   = 2,
    parameter int TURN_C = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic ready,
    input  logic host_req,
    input  logic host_we,
    output logic accept,
    output logic capture,
    output logic mem_ce_n,
    output logic mem_oe_n,
    output logic mem_we_n,
    output logic mem_dq_oe,
    output logic host_ack
);
    localparam int MAX_C = imax(imax(ASU_C, WP_C), imax(imax(WH_C, RD_C), TURN_C));
    localparam int CW    = $clog2(MAX_C + 1);
    localparam int WCW   = $clog2(WP_C + 2);

    ctrl_state_e   state_q, state_d;
    logic          turn_q;
    logic          last;
    logic          load;
    logic [CW-1:0] len_d;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP:   if (ready) state_d = ST_IDLE;
            ST_IDLE: begin
                if (host_req) begin
                    if (!host_we)    state_d = ST_RSTROBE;
                    else if (turn_q) state_d = ST_TURN;
                    else             state_d = ST_WSETUP;
                end
            end
            ST_TURN:    if (last) state_d = ST_WSETUP;
            ST_WSETUP:  if (last) state_d = ST_WPULSE;
            ST_WPULSE:  if (last) state_d = ST_WHOLD;
            ST_WHOLD:   if (last) state_d = ST_DONE;
            ST_RSTROBE: if (last) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // phase length of the state being entered
    always_comb begin
        unique case (state_d)
            ST_TURN:    len_d = CW'(TURN_C);
            ST_WSETUP:  len_d = CW'(ASU_C);
            ST_WPULSE:  len_d = CW'(WP_C);
            ST_WHOLD:   len_d = CW'(WH_C);
            ST_RSTROBE: len_d = CW'(RD_C);
            default:    len_d = CW'(1);
        endcase
    end

    assign load    = (state_d != state_q);
    assign accept  = (state_q == ST_IDLE) && host_req;
    assign capture = (state_q == ST_RSTROBE) && last;

    sram_phase_timer #(.CW(CW)) phase_i (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .len  (len_d),
        .last (last)
    );

    // state register and read/write history
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PWRUP;
            turn_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (capture)                 turn_q <= 1'b1;
            else if (state_d == ST_WSETUP) turn_q <= 1'b0;
        end
    end

    // registered pin outputs decoded from the next state
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_ce_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
            host_ack  <= 1'b0;
        end else begin
            mem_ce_n  <= !(state_d inside {ST_WSETUP, ST_WPULSE, ST_WHOLD, ST_RSTROBE});
            mem_oe_n  <= (state_d != ST_RSTROBE);
            mem_we_n  <= (state_d != ST_WPULSE);
            mem_dq_oe <= (state_d == ST_WPULSE);
            host_ack  <= (state_d == ST_DONE);
        end
    end

    // write pulse width tracker for the checker below
    logic [WCW-1:0] wlow_cnt;
    always_ff @(posedge clk) begin
        if (rst)            wlow_cnt <= '0;
        else if (!mem_we_n) wlow_cnt <= wlow_cnt + 1'b1;
        else                wlow_cnt <= '0;
    end

    AST_NO_EARLY_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (mem_ce_n && !host_ack)); // R1
    AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (wlow_cnt >= WCW'(WP_C))); // R2
    AST_READ_STROBES: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n)); // R3
    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n); // R4
    AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n && !mem_ce_n)); // R5
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack); // R7
    AST_ACK_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> mem_ce_n); // R8

endmodule

// File: rtl/sram_xfer_regs.sv
module sram_xfer_regs #(
    parameter int AW = 18,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          wr_sel,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    input  logic          capture,
    input  logic [DW-1:0] mem_dq_in,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic [DW-1:0] host_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            host_rdata <= '0;
        end else begin
            if (accept)           mem_addr   <= host_addr;
            if (accept && wr_sel) mem_dq_out <= host_wdata;
            if (capture)          host_rdata <= mem_dq_in;
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 4,
    parameter int CLK_PS     = 8000,
    parameter int T_ASU_PS   = 0,
    parameter int T_WP_PS    = 7000,
    parameter int T_DSU_PS   = 6000,
    parameter int T_WH_PS    = 0,
    parameter int T_AA_PS    = 10000,
    parameter int T_OE_PS    = 5000,
    parameter int T_HZ_PS    = 5000,
    parameter int T_PWRUP_PS = 100_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int ASU_C  = ps_to_cyc(T_ASU_PS, CLK_PS);
    localparam int WP_C   = imax(ps_to_cyc(T_WP_PS, CLK_PS), ps_to_cyc(T_DSU_PS, CLK_PS));
    localparam int WH_C   = ps_to_cyc(T_WH_PS, CLK_PS);
    localparam int RD_C   = imax(ps_to_cyc(T_AA_PS, CLK_PS), ps_to_cyc(T_OE_PS, CLK_PS));
    localparam int TURN_C = ps_to_cyc(T_HZ_PS, CLK_PS);
    localparam int PWR_C  = ps_to_cyc(T_PWRUP_PS, CLK_PS);

    logic ready;
    logic accept;
    logic capture;

    sram_pwrup_timer #(.CYCLES(PWR_C)) pwrup_i (
        .clk   (clk),
        .rst   (rst),
        .ready (ready)
    );

    sram_seq_fsm #(
        .ASU_C  (ASU_C),
        .WP_C   (WP_C),
        .WH_C   (WH_C),
        .RD_C   (RD_C),
        .TURN_C (TURN_C)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .ready     (ready),
        .host_req  (host_req),
        .host_we   (host_we),
        .accept    (accept),
        .capture   (capture),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_dq_oe (mem_dq_oe),
        .host_ack  (host_ack)
    );

    sram_xfer_regs #(.AW(ADDR_W), .DW(DATA_W)) regs_i (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .wr_sel     (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .capture    (capture),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .host_rdata (host_rdata)
    );

    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R10

endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;

    localparam int PWR_C    = 12500;
    localparam int WR_LAT   = 4;
    localparam int RD_LAT   = 3;
    localparam int TURN_LAT = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [17:0] host_addr = '0;
    logic [3:0]  host_wdata = '0;
    logic        host_ack;
    logic [3:0]  host_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [3:0]  mem_dq_out;
    logic [3:0]  mem_dq_in;

    always #4 clk = ~clk;

    sram_async_ctrl dut_i (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int viol_r1 = 0, viol_r4 = 0, viol_r5 = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) cyc = 0;
        else     cyc = cyc + 1;
    end

    // ---------------- behavioural RAM model ----------------
    logic [3:0]  ram [int];
    logic        rd_late = 1'b0;
    int          rd_cnt = 0;
    logic [3:0]  rd_val = 4'h0;
    logic        wr_pend = 1'b0;
    logic [17:0] wr_a = '0;
    logic [3:0]  wr_d = '0;
    logic        rd_cond, ram_drive;

    assign rd_cond   = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign ram_drive = rd_cond || rd_late;
    assign mem_dq_in = ram_drive ? rd_val : 4'h0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_ce_n && cyc < PWR_C) viol_r1++;
            if (!mem_we_n && !mem_oe_n) viol_r4++;
            if (mem_dq_oe && ram_drive) viol_r5++;
            if (mem_dq_oe && (mem_we_n || mem_ce_n)) viol_r5++;
            if (!mem_ce_n && !mem_we_n) begin
                wr_pend = 1'b1;
                wr_a    = mem_addr;
                wr_d    = mem_dq_oe ? mem_dq_out : 4'h0;
            end else if (wr_pend) begin
                ram[int'(wr_a)] = wr_d;
                wr_pend = 1'b0;
            end
            if (rd_cond) rd_cnt++;
            else         rd_cnt = 0;
            rd_late = rd_cond;
            begin
                logic [3:0] v;
                v = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 4'h0;
                rd_val = (rd_cnt >= 2) ? v : ~v;  // corrupt until access time met
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit         is_rd;
        logic [3:0] data;
        int         lat;
        int         start;
        string      tag;
    } exp_t;

    exp_t       sbq[$];
    logic [3:0] ref_mem [int];
    bit         last_rd = 1'b0;
    logic       ack_d = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (host_ack) begin
                chk(!ack_d, "R7", "ack wider than one cycle", int'(ack_d), 0);
                if (sbq.size() == 0) begin
                    chk(1'b0, "R7", "ack with no request", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    if (e.lat < 0)
                        chk(cyc >= PWR_C, e.tag, "ack before power-up wait", cyc, PWR_C);
                    else
                        chk((cyc - e.start) == e.lat, e.tag, "ack latency",
                            cyc - e.start, e.lat);
                    if (e.is_rd)
                        chk(host_rdata == e.data, e.tag, "read data",
                            int'(host_rdata), int'(e.data));
                end
            end
            ack_d = host_ack;
        end
    end

    function automatic logic [3:0] exp_code(input bit we, input int turn, input int n);
        if (we) begin
            if (n <= turn)     return 4'b1110;
            if (n == turn + 1) return 4'b0110;
            if (n == turn + 2) return 4'b0101;
            if (n == turn + 3) return 4'b0110;
            return 4'b1110;
        end
        if (n <= 2) return 4'b0010;
        return 4'b1110;
    endfunction

    task automatic do_acc(input bit we, input logic [17:0] a, input logic [3:0] d,
                          input bit pat, input string tag);
        exp_t e;
        int   turn;
        int   n;
        bit   got;
        turn = (we && last_rd) ? TURN_LAT : 0;
        @(negedge clk);
        host_req   = 1'b1;
        host_we    = we;
        host_addr  = a;
        host_wdata = d;
        e.is_rd = !we;
        e.data  = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 4'h0;
        e.lat   = pat ? (we ? WR_LAT + turn : RD_LAT) : -1;
        e.start = cyc;
        e.tag   = tag;
        sbq.push_back(e);
        if (we) ref_mem[int'(a)] = d;
        last_rd = !we;
        n   = 0;
        got = 1'b0;
        while (!got) begin
            @(negedge clk);
            n++;
            if (pat) begin
                logic [3:0] code, expc;
                code = {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe};
                expc = exp_code(we, turn, n);
                chk(code == expc, tag, "strobe code", int'(code), int'(expc));
                if (!mem_ce_n)
                    chk(mem_addr == a, "R10", "address while selected",
                        int'(mem_addr), int'(a));
                if (mem_dq_oe)
                    chk(mem_dq_out == d, "R2", "write data on bus",
                        int'(mem_dq_out), int'(d));
            end
            if (host_ack) got = 1'b1;
        end
        host_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R8: reset state
        chk({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, host_ack} == 5'b11100, "R8",
            "reset strobes", int'({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, host_ack}),
            int'(5'b11100));
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1: request held through the power-up wait
        do_acc(1'b1, 18'h00005, 4'hA, 1'b0, "R1");
        // R3: read back, read after write gets no turnaround
        do_acc(1'b0, 18'h00005, 4'h0, 1'b1, "R3");
        // R6: write after read gets turnaround
        do_acc(1'b1, 18'h3FFFF, 4'h5, 1'b1, "R6");
        // R2: write after write
        do_acc(1'b1, 18'h00000, 4'hC, 1'b1, "R2");
        do_acc(1'b1, 18'h15555, 4'h3, 1'b1, "R2");
        do_acc(1'b1, 18'h2AAAA, 4'hF, 1'b1, "R2");
        // R3: read after read, boundary addresses
        do_acc(1'b0, 18'h3FFFF, 4'h0, 1'b1, "R3");
        do_acc(1'b0, 18'h00000, 4'h0, 1'b1, "R3");
        do_acc(1'b0, 18'h15555, 4'h0, 1'b1, "R3");
        do_acc(1'b0, 18'h2AAAA, 4'h0, 1'b1, "R3");
        // R9: read value held across a write and idle time
        do_acc(1'b1, 18'h00123, 4'h6, 1'b1, "R6");
        chk(host_rdata == 4'hF, "R9", "read data after write", int'(host_rdata), 15);
        repeat (4) @(negedge clk);
        chk(host_rdata == 4'hF, "R9", "read data after idle", int'(host_rdata), 15);
        chk(mem_ce_n == 1'b1, "R8", "chip enable while idle", int'(mem_ce_n), 1);
        // overwrite then read, then write after read again
        do_acc(1'b1, 18'h00005, 4'h9, 1'b1, "R2");
        do_acc(1'b0, 18'h00005, 4'h0, 1'b1, "R3");
        do_acc(1'b0, 18'h00123, 4'h0, 1'b1, "R3");
        do_acc(1'b1, 18'h00124, 4'h1, 1'b1, "R6");
        do_acc(1'b0, 18'h00124, 4'h0, 1'b1, "R3");
        repeat (3) @(negedge clk);
        chk(viol_r1 == 0, "R1", "selected before power-up wait", viol_r1, 0);
        chk(viol_r4 == 0, "R4", "write enable low with output enable low", viol_r4, 0);
        chk(viol_r5 == 0, "R5", "bus drive outside write pulse or contention", viol_r5, 0);
        chk(sbq.size() == 0, "R7", "requests left unacknowledged", sbq.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule